// File: doc/BRIEF.md
# Operand Bypass Select and Load-Use Interlock

This block steers operands for a five-stage in-order pipeline whose stages run fetch, decode, execute, buffer/data and write-back. The instruction in decode presents three source register numbers, and up to two destination register numbers with their write enables and a load flag. The block keeps a shadow of the destination tags of the instructions in execute, buffer/data and write-back. Each source is compared against those tags. The resulting choice is registered into execute, where it selects the operand value. The candidates are the value read from the register file and six forwarded values: two write ports from each of three result registers.

The result registers are named by how far the producer is ahead of the consumer when the consumer reaches execute. X holds results one instruction ahead, latched at the end of execute. M holds results two ahead, latched at the end of buffer/data, which is where loaded data first appears. W holds results three ahead and retains the value just written back. Only write port 0 of a load carries memory data. When a load in execute targets, through port 0, a register that the decode instruction reads, the block raises `stall` for exactly one cycle. Fetch and decode must hold during that cycle, and the block places a bubble with no write enables into execute.

Top module: `hz_fwd_unit`

## Requirements
- R1: After reset, `stall` is 0, `ex_we` is 0 and every `opnd_sel` is 0 (register file) while decode presents no used sources.
- R2: `opnd_sel` codes are 0 = register file, 1 = X port 0, 2 = X port 1, 3 = M port 0, 4 = M port 1, 5 = W port 0, 6 = W port 1. `opnd_data` always equals the value picked by the current code.
- R3: One cycle after a non-stalled decode, each used source whose register number matches an enabled destination of the instruction then in execute, buffer/data or write-back gets the code of that stage and port.
- R4: When several enabled destinations match, the youngest stage wins. Within one stage, port 0 wins over port 1.
- R5: `stall` is high, combinationally in the same cycle, exactly when a used source matches port 0 of an enabled load in execute. It never stays high for two cycles in a row.
- R6: In the cycle after a stall, `ex_we` is 0 and every `opnd_sel` is 0. The held consumer then receives the loaded value from M port 0.
- R7: Source register 15 always selects code 0 and never causes a stall.
- R8: A source that is not marked used, or a destination whose write enable is 0, never produces a match or a stall.
- R9: A load's port-1 destination is forwarded like an ALU result and causes no stall.
- R10: `ex_we` shows the write enables of the instruction currently in execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| dec_src_tag | input | 3x4 | Source register numbers of the decode instruction |
| dec_src_used | input | 3 | Source is actually read |
| dec_dst_tag | input | 2x4 | Destination register numbers, ports 0 and 1 |
| dec_dst_we | input | 2 | Destination write enables |
| dec_is_load | input | 1 | Port 0 result comes from memory |
| rf_data | input | 3x32 | Register file values latched for execute |
| x_data | input | 2x32 | Result register X, ports 0 and 1 |
| m_data | input | 2x32 | Result register M, ports 0 and 1 |
| w_data | input | 2x32 | Result register W, ports 0 and 1 |
| stall | output | 1 | Hold fetch and decode, insert bubble |
| ex_we | output | 2 | Write enables of the execute-stage instruction |
| opnd_sel | output | 3x3 | Registered operand source code per source |
| opnd_data | output | 3x32 | Selected operand values |

## Verification
A corrupted tag or enable in the shadow stages shows at the ports within one to three cycles. It appears as a wrong `opnd_sel` code and wrong `opnd_data` for a consumer placed that many instructions behind the damaged producer. A wrong load flag shows in the same cycle as a missing or spurious `stall`, and one cycle later as a nonzero `ex_we` during a bubble. Random streams drawn over a small register range produce frequent multi-stage matches. Directed sequences pin down load-use, port priority, register 15 and disabled writes.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int NSRC = 3;  // source operands per instruction
  localparam int NWP  = 2;  // write ports per instruction
  localparam int NSTG = 3;  // shadowed stages: execute, buffer/data, write-back

  typedef enum logic [2:0] {
    SEL_RF = 3'd0,
    SEL_X0 = 3'd1,
    SEL_X1 = 3'd2,
    SEL_M0 = 3'd3,
    SEL_M1 = 3'd4,
    SEL_W0 = 3'd5,
    SEL_W1 = 3'd6
  } fwd_sel_e;
endpackage

// File: rtl/hz_stage_pipe.sv
module hz_stage_pipe
  import hz_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   stall,
  input  logic [NWP-1:0][TAG_W-1:0]              dec_dst_tag,
  input  logic [NWP-1:0]                         dec_dst_we,
  input  logic                                   dec_is_load,
  output logic [NSTG-1:0][NWP-1:0][TAG_W-1:0]    stg_tag,
  output logic [NSTG-1:0][NWP-1:0]               stg_we,
  output logic                                   ex_load
);
  logic [NSTG-1:0][NWP-1:0][TAG_W-1:0] tag_d;
  logic [NSTG-1:0][NWP-1:0]            we_d;
  logic                                ld_d;

  // next state: decode enters execute unless a bubble is forced
  always_comb begin
    tag_d[0] = dec_dst_tag;
    we_d[0]  = stall ? '0 : dec_dst_we;
    ld_d     = !stall && dec_is_load;
    for (int s = 1; s < NSTG; s++) begin
      tag_d[s] = stg_tag[s-1];
      we_d[s]  = stg_we[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_tag <= '0;
      stg_we  <= '0;
      ex_load <= 1'b0;
    end else begin
      stg_tag <= tag_d;
      stg_we  <= we_d;
      ex_load <= ld_d;
    end
  end
endmodule

// File: rtl/hz_src_match.sv
module hz_src_match
  import hz_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int PC_TAG = 15
) (
  input  logic [TAG_W-1:0]                    src_tag,
  input  logic                                src_used,
  input  logic [NSTG-1:0][NWP-1:0][TAG_W-1:0] stg_tag,
  input  logic [NSTG-1:0][NWP-1:0]            stg_we,
  input  logic                                ex_load,
  output fwd_sel_e                            sel,
  output logic                                load_hit
);
  logic eligible;

  assign eligible = src_used && (src_tag != TAG_W'(PC_TAG));

  // oldest first, port 1 before port 0: the last hit written wins
  always_comb begin
    sel = SEL_RF;
    if (eligible) begin
      for (int s = NSTG - 1; s >= 0; s--) begin
        for (int p = NWP - 1; p >= 0; p--) begin
          if (stg_we[s][p] && (stg_tag[s][p] == src_tag))
            sel = fwd_sel_e'(3'(1 + NWP * s + p));
        end
      end
    end
  end

  assign load_hit = eligible && ex_load && stg_we[0][0] && (stg_tag[0][0] == src_tag);
endmodule

// File: rtl/hz_opnd_mux.sv
module hz_opnd_mux
  import hz_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwd_sel_e                      sel,
  input  logic [DATA_W-1:0]             rf_val,
  input  logic [NWP-1:0][DATA_W-1:0]    x_val,
  input  logic [NWP-1:0][DATA_W-1:0]    m_val,
  input  logic [NWP-1:0][DATA_W-1:0]    w_val,
  output logic [DATA_W-1:0]             out_val
);
  always_comb begin
    case (sel)
      SEL_X0:  out_val = x_val[0];
      SEL_X1:  out_val = x_val[1];
      SEL_M0:  out_val = m_val[0];
      SEL_M1:  out_val = m_val[1];
      SEL_W0:  out_val = w_val[0];
      SEL_W1:  out_val = w_val[1];
      default: out_val = rf_val;
    endcase
  end
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int PC_TAG = 15
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NSRC-1:0][TAG_W-1:0]         dec_src_tag,
  input  logic [NSRC-1:0]                    dec_src_used,
  input  logic [NWP-1:0][TAG_W-1:0]          dec_dst_tag,
  input  logic [NWP-1:0]                     dec_dst_we,
  input  logic                               dec_is_load,
  input  logic [NSRC-1:0][DATA_W-1:0]        rf_data,
  input  logic [NWP-1:0][DATA_W-1:0]         x_data,
  input  logic [NWP-1:0][DATA_W-1:0]         m_data,
  input  logic [NWP-1:0][DATA_W-1:0]         w_data,
  output logic                               stall,
  output logic [NWP-1:0]                     ex_we,
  output logic [NSRC-1:0][2:0]               opnd_sel,
  output logic [NSRC-1:0][DATA_W-1:0]        opnd_data
);
  logic [NSTG-1:0][NWP-1:0][TAG_W-1:0] stg_tag;
  logic [NSTG-1:0][NWP-1:0]            stg_we;
  logic                                ex_load;
  logic [NSRC-1:0]                     load_hit;
  fwd_sel_e                            sel_c [NSRC];
  fwd_sel_e                            sel_d [NSRC];
  fwd_sel_e                            sel_q [NSRC];

  hz_stage_pipe #(.TAG_W(TAG_W)) u_pipe (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall       (stall),
    .dec_dst_tag (dec_dst_tag),
    .dec_dst_we  (dec_dst_we),
    .dec_is_load (dec_is_load),
    .stg_tag     (stg_tag),
    .stg_we      (stg_we),
    .ex_load     (ex_load)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_src_match #(.TAG_W(TAG_W), .PC_TAG(PC_TAG)) u_match (
      .src_tag  (dec_src_tag[g]),
      .src_used (dec_src_used[g]),
      .stg_tag  (stg_tag),
      .stg_we   (stg_we),
      .ex_load  (ex_load),
      .sel      (sel_c[g]),
      .load_hit (load_hit[g])
    );

    hz_opnd_mux #(.DATA_W(DATA_W)) u_mux (
      .sel     (sel_q[g]),
      .rf_val  (rf_data[g]),
      .x_val   (x_data),
      .m_val   (m_data),
      .w_val   (w_data),
      .out_val (opnd_data[g])
    );

    assign opnd_sel[g] = sel_q[g];
  end

  assign stall = |load_hit;
  assign ex_we = stg_we[0];

  // a bubble carries the register-file code
  always_comb begin
    for (int i = 0; i < NSRC; i++)
      sel_d[i] = stall ? SEL_RF : sel_c[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) sel_q[i] <= SEL_RF;
    end else begin
      for (int i = 0; i < NSRC; i++) sel_q[i] <= sel_d[i];
    end
  end
endmodule

// File: rtl/hz_fwd_checker.sv
module hz_fwd_checker
  import hz_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int PC_TAG = 15
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        stall,
  input logic [NWP-1:0]              ex_we,
  input logic [NSRC-1:0][TAG_W-1:0]  dec_src_tag,
  input logic [NSRC-1:0]             dec_src_used,
  input logic [NSRC-1:0][2:0]        opnd_sel,
  input logic [NSRC-1:0][DATA_W-1:0] opnd_data,
  input logic [NSRC-1:0][DATA_W-1:0] rf_data
);
  a_r5_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  a_r6_bubble_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (ex_we == '0));

  for (genvar g = 0; g < NSRC; g++) begin : g_op
    a_r7_pc_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && dec_src_used[g] && dec_src_tag[g] == TAG_W'(PC_TAG)) |=> (opnd_sel[g] == 3'd0));

    a_r8_unused_src: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && !dec_src_used[g]) |=> (opnd_sel[g] == 3'd0));

    a_r6_bubble_sel: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (opnd_sel[g] == 3'd0));

    a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      opnd_sel[g] != 3'd7);

    a_r2_rf_path: assert property (@(posedge clk) disable iff (!rst_n)
      (opnd_sel[g] == 3'd0) |-> (opnd_data[g] == rf_data[g]));
  end
endmodule

bind hz_fwd_unit hz_fwd_checker #(.DATA_W(DATA_W), .TAG_W(TAG_W), .PC_TAG(PC_TAG)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stall        (stall),
  .ex_we        (ex_we),
  .dec_src_tag  (dec_src_tag),
  .dec_src_used (dec_src_used),
  .opnd_sel     (opnd_sel),
  .opnd_data    (opnd_data),
  .rf_data      (rf_data)
);

// File: tb/sim_hz_fwd_unit.sv
module sim_hz_fwd_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int TW = 4;

  logic clk, rst_n;
  logic [2:0][TW-1:0] src_tag;
  logic [2:0]         src_used;
  logic [1:0][TW-1:0] dst_tag;
  logic [1:0]         dst_we;
  logic               is_load;
  logic [2:0][DW-1:0] rf_d;
  logic [1:0][DW-1:0] x_d, m_d, w_d;
  logic               stall;
  logic [1:0]         ex_we;
  logic [2:0][2:0]    opnd_sel;
  logic [2:0][DW-1:0] opnd_data;

  // staged decode values, applied unless decode is held
  logic [2:0][TW-1:0] s_src_tag;
  logic [2:0]         s_src_used;
  logic [1:0][TW-1:0] s_dst_tag;
  logic [1:0]         s_dst_we;
  logic               s_load;

  // reference model state
  logic [2:0][1:0][TW-1:0] m_tag;
  logic [2:0][1:0]         m_we;
  logic                    m_ld;
  int                      m_sel [3];
  bit                      held;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  hz_fwd_unit #(.DATA_W(DW), .TAG_W(TW), .PC_TAG(15)) u0 (
    .clk(clk), .rst_n(rst_n),
    .dec_src_tag(src_tag), .dec_src_used(src_used),
    .dec_dst_tag(dst_tag), .dec_dst_we(dst_we), .dec_is_load(is_load),
    .rf_data(rf_d), .x_data(x_d), .m_data(m_d), .w_data(w_d),
    .stall(stall), .ex_we(ex_we), .opnd_sel(opnd_sel), .opnd_data(opnd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // youngest stage first, port 0 first; register 15 and unused sources excluded
  function automatic int exp_sel(input int i);
    if (!src_used[i] || src_tag[i] == 4'd15) return 0;
    for (int s = 0; s < 3; s++)
      for (int p = 0; p < 2; p++)
        if (m_we[s][p] && m_tag[s][p] == src_tag[i]) return 1 + 2 * s + p;
    return 0;
  endfunction

  function automatic bit exp_stall();
    bit r = 0;
    for (int i = 0; i < 3; i++)
      if (src_used[i] && src_tag[i] != 4'd15 && m_ld && m_we[0][0] && m_tag[0][0] == src_tag[i])
        r = 1;
    return r;
  endfunction

  function automatic logic [DW-1:0] exp_data(input int i, input int code);
    case (code)
      1: return x_d[0];
      2: return x_d[1];
      3: return m_d[0];
      4: return m_d[1];
      5: return w_d[0];
      6: return w_d[1];
      default: return rf_d[i];
    endcase
  endfunction

  task automatic dec_set(input int t0, input bit u0_, input int t1, input bit u1_,
                         input int t2, input bit u2_, input int d0, input bit w0,
                         input int d1, input bit w1, input bit ld);
    s_src_tag  = {TW'(t2), TW'(t1), TW'(t0)};
    s_src_used = {u2_, u1_, u0_};
    s_dst_tag  = {TW'(d1), TW'(d0)};
    s_dst_we   = {w1, w0};
    s_load     = ld;
  endtask

  task automatic cyc(input string rq);
    bit st;
    int ns [3];
    @(negedge clk);
    if (!held) begin
      src_tag = s_src_tag; src_used = s_src_used;
      dst_tag = s_dst_tag; dst_we = s_dst_we; is_load = s_load;
    end
    for (int i = 0; i < 3; i++) rf_d[i] = $urandom;
    for (int p = 0; p < 2; p++) begin
      x_d[p] = $urandom; m_d[p] = $urandom; w_d[p] = $urandom;
    end
    #1;
    for (int i = 0; i < 3; i++) begin
      chk(opnd_sel[i] == 3'(m_sel[i]), rq, "opnd_sel", opnd_sel[i], m_sel[i]);
      chk(opnd_data[i] == exp_data(i, m_sel[i]), "R2", "opnd_data", opnd_data[i], exp_data(i, m_sel[i]));
    end
    chk(ex_we == m_we[0], "R10", "ex_we", ex_we, m_we[0]);
    st = exp_stall();
    chk(stall == st, (st ? "R5" : rq), "stall", stall, st);
    for (int i = 0; i < 3; i++) ns[i] = st ? 0 : exp_sel(i);
    m_tag[2] = m_tag[1]; m_we[2] = m_we[1];
    m_tag[1] = m_tag[0]; m_we[1] = m_we[0];
    m_tag[0] = dst_tag;
    m_we[0]  = st ? 2'b00 : dst_we;
    m_ld     = !st && is_load;
    for (int i = 0; i < 3; i++) m_sel[i] = ns[i];
    held = st;
  endtask

  function automatic int rtag();
    int t = $urandom % 8;
    return (t == 7) ? 15 : t;
  endfunction

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    src_tag = '0; src_used = '0; dst_tag = '0; dst_we = '0; is_load = 1'b0;
    rf_d = '0; x_d = '0; m_d = '0; w_d = '0;
    m_tag = '0; m_we = '0; m_ld = 1'b0; held = 0;
    for (int i = 0; i < 3; i++) m_sel[i] = 0;
    dec_set(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(stall == 1'b0, "R1", "stall", stall, 0);
    chk(ex_we == 2'b00, "R1", "ex_we", ex_we, 0);
    for (int i = 0; i < 3; i++) chk(opnd_sel[i] == 3'd0, "R1", "opnd_sel", opnd_sel[i], 0);

    // R3: result of the previous instruction comes from X
    dec_set(0, 0, 0, 0, 0, 0, 2, 1, 0, 0, 0); cyc("R3");
    dec_set(2, 1, 0, 0, 2, 1, 0, 0, 0, 0, 0); cyc("R3");
    dec_set(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); cyc("R3");
    // R4: several producers of r4, youngest and port 0 must win
    dec_set(0, 0, 0, 0, 0, 0, 4, 1, 5, 1, 0); cyc("R4");
    dec_set(0, 0, 0, 0, 0, 0, 4, 1, 4, 1, 0); cyc("R4");
    dec_set(0, 0, 0, 0, 0, 0, 1, 1, 4, 1, 0); cyc("R4");
    dec_set(4, 1, 5, 1, 0, 0, 0, 0, 0, 0, 0); cyc("R4");
    dec_set(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); cyc("R4");
    // R5 and R6: load r3 then immediate use, held one cycle, then M port 0
    dec_set(0, 0, 0, 0, 0, 0, 3, 1, 0, 0, 1); cyc("R5");
    dec_set(1, 0, 3, 1, 0, 0, 8, 1, 0, 0, 0); cyc("R5");
    cyc("R6");
    dec_set(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); cyc("R6");
    cyc("R6");
    // R9: load port 1 target is not a load-use hazard
    dec_set(0, 0, 0, 0, 0, 0, 7, 1, 6, 1, 1); cyc("R9");
    dec_set(6, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0); cyc("R9");
    dec_set(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); cyc("R9");
    // R7: register 15 never forwarded, even behind a load of r15
    dec_set(0, 0, 0, 0, 0, 0, 15, 1, 0, 0, 1); cyc("R7");
    dec_set(15, 1, 15, 1, 15, 1, 0, 0, 0, 0, 0); cyc("R7");
    dec_set(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); cyc("R7");
    // R8: disabled write and unused source never match
    dec_set(0, 0, 0, 0, 0, 0, 9, 0, 9, 0, 1); cyc("R8");
    dec_set(9, 1, 0, 0, 0, 0, 10, 1, 0, 0, 1); cyc("R8");
    dec_set(10, 0, 10, 0, 10, 0, 0, 0, 0, 0, 0); cyc("R8");
    dec_set(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); cyc("R8");

    // random mix
    for (int n = 0; n < 600; n++) begin
      dec_set(rtag(), ($urandom % 4) != 0, rtag(), ($urandom % 4) != 0,
              rtag(), ($urandom % 4) != 0, rtag(), ($urandom % 4) != 0,
              rtag(), ($urandom % 3) == 0, ($urandom % 3) == 0);
      cyc("R3");
    end
    dec_set(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (4) cyc("R4");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule